// File: doc/BRIEF.md
# UART Receive Status Flags

This block sits on the receive side of a UART, between the byte assembler and software. It takes finished bytes from the shift register and holds them in a small first-in first-out store. It keeps three sticky status bits: data pending, line gone idle, and data lost to overflow. It also drives one interrupt request for each of them, gated by enable inputs. Baud timing, bit sampling and the transmit side belong to other blocks.

Bytes are read out of the store oldest first through a read strobe. A flush input drops everything at once. The idle bit records one idle period per burst of new data and is blocked while the receiver is muted. The overflow bit keeps what is already stored and drops the byte that did not fit. A configuration input switches overflow reporting off completely.

Top module: `uart_rx_status`

## Requirements
- R1: While reset is held and right after it is released, avail_o, idle_o, ovr_o and all three interrupt outputs are 0.
- R2: avail_o is 1 exactly when the store holds at least one byte. A byte strobed in on byte_done_i is counted from the next clock edge. rd_data_o always shows the oldest stored byte, and bytes leave in the order they arrived.
- R3: Each rd_i pulse while the store is not empty removes exactly one byte. rd_i while the store is empty changes nothing.
- R4: flush_i empties the store at the next edge. It wins over a read in the same cycle, and a byte strobed in that same cycle is dropped without raising an overflow.
- R5: idle_o is set at the edge after an accepted idle_det_i pulse and stays set until idle_clr_i. When a set and a clear fall in the same cycle, the set wins.
- R6: After an idle pulse has been accepted, further idle_det_i pulses are ignored until a new byte has been accepted into the store. A byte dropped by overflow or flush does not re-arm the flag. The bit starts out armed after reset.
- R7: When mute_en_i and muted_i are both 1, idle_det_i is ignored and does not use up the armed state. With mute_en_i at 0, muted_i has no effect.
- R8: byte_done_i while the store is full (judged on the occupancy at the start of the cycle, even if a read occurs in that cycle) sets ovr_o at the next edge. The new byte is dropped and the stored bytes are unchanged. ovr_o clears only on ovr_clr_i, and a set wins over a clear in the same cycle.
- R9: While ovr_dis_i is 1, ovr_o reads 0 in that same cycle and no overflow is recorded. A byte arriving at a full store is still dropped.
- R10: irq_avail_o = avail_o & ie_avail_i. irq_idle_o = idle_o & ie_idle_i. irq_ovr_o = ovr_o & (ie_avail_i | ie_err_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_done_i | input | 1 | Shift register holds a finished byte |
| byte_data_i | input | DW | Finished byte value |
| idle_det_i | input | 1 | Idle line seen by the line sampler |
| mute_en_i | input | 1 | Mute operation configured |
| muted_i | input | 1 | Receiver is currently muted |
| ovr_dis_i | input | 1 | Switches overflow reporting off |
| flush_i | input | 1 | Empties the store |
| idle_clr_i | input | 1 | Write-one-to-clear for idle_o |
| ovr_clr_i | input | 1 | Write-one-to-clear for ovr_o |
| rd_i | input | 1 | Read strobe, pops the oldest byte |
| ie_avail_i | input | 1 | Enable for the data-pending interrupt |
| ie_idle_i | input | 1 | Enable for the idle interrupt |
| ie_err_i | input | 1 | Enable for the error interrupt |
| rd_data_o | output | DW | Oldest stored byte |
| avail_o | output | 1 | Store holds data |
| idle_o | output | 1 | Idle flag |
| ovr_o | output | 1 | Overflow flag |
| irq_avail_o | output | 1 | Data-pending interrupt |
| irq_idle_o | output | 1 | Idle interrupt |
| irq_ovr_o | output | 1 | Overflow interrupt |

## Verification
The collision of interest is a flag being set while software clears it in the same cycle. One case is an overflowing byte arriving on the same cycle as ovr_clr_i. The other is an idle pulse arriving on the same cycle as idle_clr_i. Both are provoked with directed steps on a full store and on an armed idle flag, and also occur often in the random phase because clear strobes are issued freely. The bench model applies "set wins" and compares the flag one edge later. A second collision, read and write on a full store, is judged by checking that the overflow still fires and that the byte order stays intact.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;

    typedef struct packed {
        logic idle;
        logic armed;
        logic ovr;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{idle: 1'b0, armed: 1'b1, ovr: 1'b0};

endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_i,
    input  logic          flush_i,
    output logic [DW-1:0] rd_data_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          wr_accept_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign full_o      = (ctrl_q.count == CW'(DEPTH));
    assign empty_o     = (ctrl_q.count == '0);
    assign do_wr       = wr_i && !full_o && !flush_i;
    assign do_rd       = rd_i && !empty_o && !flush_i;
    assign wr_accept_o = do_wr;
    assign rd_data_o   = mem_q[ctrl_q.rd_ptr];

    always_comb begin
        ctrl_d = ctrl_q;
        if (flush_i) begin
            ctrl_d = '0;
        end else begin
            if (do_wr) ctrl_d.wr_ptr = bump(ctrl_q.wr_ptr);
            if (do_rd) ctrl_d.rd_ptr = bump(ctrl_q.rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   ctrl_d.count = ctrl_q.count + 1'b1;
                2'b01:   ctrl_d.count = ctrl_q.count - 1'b1;
                default: ctrl_d.count = ctrl_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (do_wr && (ctrl_q.wr_ptr == AW'(i))) mem_q[i] <= wr_data_i;
        end
    end

endmodule

// File: rtl/rxs_flags.sv
module rxs_flags
    import uart_rx_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_done_i,
    input  logic fifo_full_i,
    input  logic wr_accept_i,
    input  logic flush_i,
    input  logic idle_det_i,
    input  logic mute_en_i,
    input  logic muted_i,
    input  logic ovr_dis_i,
    input  logic idle_clr_i,
    input  logic ovr_clr_i,
    output logic idle_o,
    output logic ovr_o
);
    flag_state_t st_d, st_q;
    logic idle_set, ovr_set;

    assign idle_set = idle_det_i && st_q.armed && !(mute_en_i && muted_i);
    assign ovr_set  = byte_done_i && fifo_full_i && !flush_i && !ovr_dis_i;

    always_comb begin
        st_d = st_q;
        if (idle_set)        st_d.idle = 1'b1;
        else if (idle_clr_i) st_d.idle = 1'b0;

        if (wr_accept_i)     st_d.armed = 1'b1;
        else if (idle_set)   st_d.armed = 1'b0;

        if (ovr_dis_i)       st_d.ovr = 1'b0;
        else if (ovr_set)    st_d.ovr = 1'b1;
        else if (ovr_clr_i)  st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_RESET;
        else        st_q <= st_d;
    end

    assign idle_o = st_q.idle;
    assign ovr_o  = st_q.ovr && !ovr_dis_i;

endmodule

// File: rtl/rxs_irq.sv
module rxs_irq (
    input  logic avail_i,
    input  logic idle_i,
    input  logic ovr_i,
    input  logic ie_avail_i,
    input  logic ie_idle_i,
    input  logic ie_err_i,
    output logic irq_avail_o,
    output logic irq_idle_o,
    output logic irq_ovr_o
);
    always_comb begin
        irq_avail_o = avail_i && ie_avail_i;
        irq_idle_o  = idle_i && ie_idle_i;
        irq_ovr_o   = ovr_i && (ie_avail_i || ie_err_i);
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done_i,
    input  logic [DW-1:0] byte_data_i,
    input  logic          idle_det_i,
    input  logic          mute_en_i,
    input  logic          muted_i,
    input  logic          ovr_dis_i,
    input  logic          flush_i,
    input  logic          idle_clr_i,
    input  logic          ovr_clr_i,
    input  logic          rd_i,
    input  logic          ie_avail_i,
    input  logic          ie_idle_i,
    input  logic          ie_err_i,
    output logic [DW-1:0] rd_data_o,
    output logic          avail_o,
    output logic          idle_o,
    output logic          ovr_o,
    output logic          irq_avail_o,
    output logic          irq_idle_o,
    output logic          irq_ovr_o
);
    logic fifo_empty, fifo_full, wr_accept;

    rxs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (byte_done_i),
        .wr_data_i  (byte_data_i),
        .rd_i       (rd_i),
        .flush_i    (flush_i),
        .rd_data_o  (rd_data_o),
        .empty_o    (fifo_empty),
        .full_o     (fifo_full),
        .wr_accept_o(wr_accept)
    );

    assign avail_o = !fifo_empty;

    rxs_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_done_i(byte_done_i),
        .fifo_full_i(fifo_full),
        .wr_accept_i(wr_accept),
        .flush_i    (flush_i),
        .idle_det_i (idle_det_i),
        .mute_en_i  (mute_en_i),
        .muted_i    (muted_i),
        .ovr_dis_i  (ovr_dis_i),
        .idle_clr_i (idle_clr_i),
        .ovr_clr_i  (ovr_clr_i),
        .idle_o     (idle_o),
        .ovr_o      (ovr_o)
    );

    rxs_irq u_irq (
        .avail_i    (avail_o),
        .idle_i     (idle_o),
        .ovr_i      (ovr_o),
        .ie_avail_i (ie_avail_i),
        .ie_idle_i  (ie_idle_i),
        .ie_err_i   (ie_err_i),
        .irq_avail_o(irq_avail_o),
        .irq_idle_o (irq_idle_o),
        .irq_ovr_o  (irq_ovr_o)
    );

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
    input logic clk,
    input logic rst_n,
    input logic byte_done_i,
    input logic idle_det_i,
    input logic mute_en_i,
    input logic muted_i,
    input logic ovr_dis_i,
    input logic flush_i,
    input logic idle_clr_i,
    input logic ovr_clr_i,
    input logic full_i,
    input logic avail_o,
    input logic idle_o,
    input logic ovr_o,
    input logic irq_ovr_o,
    input logic irq_idle_o
);
    p_avail_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_o) |-> $past(byte_done_i));

    p_flush_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !avail_o);

    p_idle_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && !idle_clr_i) |=> idle_o);

    p_idle_needs_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(idle_det_i));

    p_idle_muted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && mute_en_i && muted_i) |=> !idle_o);

    p_ovr_on_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_i && full_i && !flush_i && !ovr_dis_i) |=> (ovr_o || ovr_dis_i));

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !ovr_clr_i) |=> (ovr_o || ovr_dis_i));

    p_ovr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_dis_i |-> !ovr_o);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovr_o |-> ovr_o) and (irq_idle_o |-> idle_o));
endmodule

bind uart_rx_status rxs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_done_i(byte_done_i),
    .idle_det_i (idle_det_i),
    .mute_en_i  (mute_en_i),
    .muted_i    (muted_i),
    .ovr_dis_i  (ovr_dis_i),
    .flush_i    (flush_i),
    .idle_clr_i (idle_clr_i),
    .ovr_clr_i  (ovr_clr_i),
    .full_i     (fifo_full),
    .avail_o    (avail_o),
    .idle_o     (idle_o),
    .ovr_o      (ovr_o),
    .irq_ovr_o  (irq_ovr_o),
    .irq_idle_o (irq_idle_o)
);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bd = 0, idet = 0, men = 0, mut = 0, odis = 0, fl = 0;
    logic iclr = 0, oclr = 0, rd = 0, iea = 0, iei = 0, iee = 0;
    logic [DW-1:0] bdat = '0;
    logic [DW-1:0] rdat;
    logic avail, idle, ovr, irq_a, irq_i, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] mq[$];
    bit m_idle = 0, m_arm = 1, m_ovr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_status #(.DW(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .byte_done_i(bd), .byte_data_i(bdat),
        .idle_det_i(idet), .mute_en_i(men), .muted_i(mut), .ovr_dis_i(odis),
        .flush_i(fl), .idle_clr_i(iclr), .ovr_clr_i(oclr), .rd_i(rd),
        .ie_avail_i(iea), .ie_idle_i(iei), .ie_err_i(iee),
        .rd_data_o(rdat), .avail_o(avail), .idle_o(idle), .ovr_o(ovr),
        .irq_avail_o(irq_a), .irq_idle_o(irq_i), .irq_ovr_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_ovr();
        return m_ovr && !odis;
    endfunction

    task automatic compare_all();
        chk(avail == (mq.size() > 0), "R2 avail", 32'(avail), 32'(mq.size() > 0));
        if (mq.size() > 0) chk(rdat == mq[0], "R2 data order", 32'(rdat), 32'(mq[0]));
        chk(idle == m_idle, "R5 idle", 32'(idle), 32'(m_idle));
        chk(ovr == exp_ovr(), "R8 ovr", 32'(ovr), 32'(exp_ovr()));
        chk(irq_a == ((mq.size() > 0) && iea), "R10 irq_avail", 32'(irq_a), 32'((mq.size() > 0) && iea));
        chk(irq_i == (m_idle && iei), "R10 irq_idle", 32'(irq_i), 32'(m_idle && iei));
        chk(irq_o == (exp_ovr() && (iea || iee)), "R10 irq_ovr", 32'(irq_o), 32'(exp_ovr() && (iea || iee)));
    endtask

    task automatic tick();
        bit full, acc, rdo, oev, iev;
        full = (mq.size() == DEPTH);
        acc  = bd && !full && !fl;
        rdo  = rd && (mq.size() > 0) && !fl;
        oev  = bd && full && !fl && !odis;
        iev  = idet && m_arm && !(men && mut);
        if (fl) mq.delete();
        else begin
            if (rdo) void'(mq.pop_front());
            if (acc) mq.push_back(bdat);
        end
        if (iev) m_idle = 1; else if (iclr) m_idle = 0;
        if (acc) m_arm = 1; else if (iev) m_arm = 0;
        if (odis) m_ovr = 0; else if (oev) m_ovr = 1; else if (oclr) m_ovr = 0;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic quiet();
        bd = 0; idet = 0; fl = 0; iclr = 0; oclr = 0; rd = 0;
    endtask

    task automatic push(input logic [DW-1:0] v);
        quiet(); bd = 1; bdat = v; tick(); quiet();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk(!avail && !idle && !ovr, "R1 flags in reset", {idle, ovr, avail}, 0);
        rst_n = 1;
        @(posedge clk); #1;
        chk(!avail && !idle && !ovr && !irq_a && !irq_i && !irq_o, "R1 after reset",
            {irq_a, irq_i, irq_o, idle, ovr, avail}, 0);

        iea = 1; iei = 1; iee = 0;
        // R2 fill, R8 overflow keeps contents
        for (int i = 0; i < DEPTH; i++) push(8'hA0 + 8'(i));
        chk(avail, "R2 full store avail", 32'(avail), 1);
        push(8'h55);
        chk(ovr == 1, "R8 overflow set", 32'(ovr), 1);
        chk(rdat == 8'hA0, "R8 head kept", 32'(rdat), 32'hA0);
        chk(irq_o == 1, "R10 ovr irq via avail enable", 32'(irq_o), 1);
        iea = 0; iee = 0; #1;
        chk(irq_o == 0, "R10 ovr irq no enable", 32'(irq_o), 0);
        iee = 1; #1;
        chk(irq_o == 1, "R10 ovr irq via err enable", 32'(irq_o), 1);
        // R8 read + write on full store still overflows, same cycle as clear: set wins
        quiet(); bd = 1; bdat = 8'h66; rd = 1; oclr = 1; tick(); quiet();
        chk(ovr == 1, "R8 set beats clear", 32'(ovr), 1);
        oclr = 1; tick(); quiet();
        chk(ovr == 0, "R8 clear", 32'(ovr), 0);
        // R3 drain, then read empty
        while (mq.size() > 0) begin rd = 1; tick(); quiet(); end
        chk(!avail, "R3 drained", 32'(avail), 0);
        rd = 1; tick(); quiet();
        chk(!avail, "R3 read when empty", 32'(avail), 0);
        push(8'h11);
        chk(rdat == 8'h11, "R3 empty read left pointers intact", 32'(rdat), 32'h11);
        // R9 overflow disabled
        for (int i = 0; i < DEPTH - 1; i++) push(8'hC0 + 8'(i));
        odis = 1; push(8'hEE);
        chk(ovr == 0, "R9 no overflow when disabled", 32'(ovr), 0);
        chk(rdat == 8'h11, "R9 byte still dropped", 32'(rdat), 32'h11);
        odis = 0; tick();
        chk(ovr == 0, "R9 nothing recorded", 32'(ovr), 0);
        // R4 flush with byte and read in same cycle
        quiet(); fl = 1; bd = 1; bdat = 8'h77; rd = 1; tick(); quiet();
        chk(!avail && !ovr, "R4 flush empties", {ovr, avail}, 0);
        // R5/R6 idle
        idet = 1; iclr = 1; tick(); quiet();
        chk(idle == 1, "R5 set beats clear", 32'(idle), 1);
        iclr = 1; tick(); quiet();
        chk(idle == 0, "R5 clear", 32'(idle), 0);
        idet = 1; tick(); quiet();
        chk(idle == 0, "R6 not re-armed", 32'(idle), 0);
        for (int i = 0; i < DEPTH; i++) push(8'h30 + 8'(i));
        iclr = 1; tick(); quiet();
        for (int i = 0; i < DEPTH; i++) begin rd = 1; tick(); quiet(); end
        push(8'h99);
        fl = 1; tick(); quiet();
        idet = 1; tick(); quiet();
        chk(idle == 1, "R6 re-armed by accepted byte", 32'(idle), 1);
        iclr = 1; tick(); quiet();
        for (int i = 0; i < DEPTH; i++) push(8'h40);
        push(8'h41);
        oclr = 1; tick(); quiet();
        idet = 1; tick(); quiet();
        chk(idle == 1, "R6 re-armed before overflow", 32'(idle), 1);
        iclr = 1; tick(); quiet();
        push(8'h42);
        idet = 1; tick(); quiet();
        chk(idle == 0, "R6 overflow byte does not re-arm", 32'(idle), 0);
        fl = 1; tick(); quiet();
        // R7 mute
        push(8'h01);
        men = 1; mut = 1; idet = 1; tick(); quiet();
        chk(idle == 0, "R7 muted idle ignored", 32'(idle), 0);
        mut = 0; idet = 1; tick(); quiet();
        chk(idle == 1, "R7 arm kept while muted", 32'(idle), 1);
        iclr = 1; tick(); quiet();
        push(8'h02);
        men = 0; mut = 1; idet = 1; tick(); quiet();
        chk(idle == 1, "R7 mute without enable", 32'(idle), 1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bd   = ($urandom % 100) < 45;
            bdat = 8'($urandom);
            rd   = ($urandom % 100) < 30;
            fl   = ($urandom % 100) < 3;
            idet = ($urandom % 100) < 12;
            iclr = ($urandom % 100) < 10;
            oclr = ($urandom % 100) < 10;
            men  = ($urandom % 2) == 0;
            mut  = ($urandom % 100) < 30;
            odis = ($urandom % 100) < 8;
            iea  = ($urandom % 2) == 0;
            iei  = ($urandom % 2) == 0;
            iee  = ($urandom % 2) == 0;
            tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule